// File: doc/BRIEF.md
# Six-Pin Bidirectional I/O Port with Clock-Out Override

This block is a memory-mapped general-purpose port of six pins that sits on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. Every pin has three signals in place of a real tri-state pad: an output value, an output enable and a sampled input level. Two registers set the pin behaviour. A value latch holds what each pin drives. A per-pin direction register decides whether that pin's driver is on.

When software reads the value register, each bit comes from the latch or from the pin, depending on that pin's direction bit. Pins set as inputs return their level after a two-flop synchronizer. Pins set as outputs return the latched value. A control bit at the top of the direction register gives pin 0 to an externally supplied clock. While that bit is set, pin 0's driver is forced on and the latch and direction bit 0 are bypassed. To change a pin from input to output without a glitch, software writes the latch first and then sets the direction bit.

Top module: `pio6_port`

## Requirements
- R1: After reset, the latch, the direction bits and the clock-out enable are all 0, every pin's output enable is 0, and every output value is 0.
- R2: Offset 0x01 is the value register and offset 0x05 is the direction register. Bit n (n = 0..5) of each register belongs to pin n. A write takes effect on the clock edge where the write strobe is high.
- R3: A pin's output enable equals its direction bit (1 = drive). Its output value equals its latch bit. This holds for every pin except pin 0 while the clock-out enable is set.
- R4: A read of 0x01 returns, for each pin, the latch bit if the direction bit is 1 and the synchronized input level if it is 0.
- R5: A write to 0x01 always updates the latch, whatever the direction bits are. For an input pin, the written value has no effect on that pin's read-back bit or on its output enable.
- R6: Input levels pass through two flops. A change on a pin appears in the read data two clock edges later.
- R7: Bit 7 of the direction register is the clock-out enable, readable and writable. While it is 1, pin 0's output enable is 1 and its output value follows the clock input combinationally. The read-back of bit 0 of 0x01 is then the synchronized pin 0 level.
- R8: Bit 6 of both registers and bit 7 of the value register always read 0, and writes to them are ignored.
- R9: A read of any offset other than 0x01 or 0x05 returns 0, and a write to such an offset changes no state.
- R10: In the cycle after a direction bit goes from 0 to 1, the pin drives the value already in the latch.
- R11: Read data is combinational from the address and the registered state. It is valid in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| ext_clk_i | input | 1 | Clock routed to pin 0 when the clock-out enable is set |
| pin_in_i | input | 6 | Raw pin input levels |
| pin_out_o | output | 6 | Pin output values |
| pin_oe_o | output | 6 | Pin output enables |

## Verification
The bench writes the latch while the pins are inputs, then turns the pins to outputs. A design that drove stale or transient data at that switch, or that gated latch writes by direction, would show the wrong pin value in the first cycle. The bench changes pin levels and reads back exactly two edges later. A missing or extra synchronizer stage then shows up as a one-cycle skew. The bench also toggles the clock-out enable against a running external clock. An override that leaked into other pins, kept the latch value, or changed the bit 0 read-back would be caught. Writes to reserved bits and unmapped offsets are followed by reads and pin checks, so decode aliasing would be reported.

// File: rtl/pio6_pkg.sv
package pio6_pkg;
    localparam int unsigned NPINS  = 6;
    localparam int unsigned AW     = 8;
    localparam int unsigned DW     = 8;
    localparam logic [AW-1:0] OFS_VAL = 8'h01;
    localparam logic [AW-1:0] OFS_DIR = 8'h05;
    localparam int unsigned CKO_BIT = 7;

    typedef struct packed {
        logic [NPINS-1:0] lat;
        logic [NPINS-1:0] dir;
        logic             cko;
    } regs_t;
endpackage

// File: rtl/pio6_regs.sv
module pio6_regs
    import pio6_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output regs_t         regs_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            if (addr_i == OFS_VAL) r_d.lat = wdata_i[NPINS-1:0];
            if (addr_i == OFS_DIR) begin
                r_d.dir = wdata_i[NPINS-1:0];
                r_d.cko = wdata_i[CKO_BIT];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign regs_o = r_q;
endmodule

// File: rtl/pio6_sync.sv
module pio6_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pio6_pad.sv
module pio6_pad
    import pio6_pkg::*;
(
    input  regs_t            regs_i,
    input  logic             ext_clk_i,
    output logic [NPINS-1:0] out_o,
    output logic [NPINS-1:0] oe_o
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (p == 0) begin : g_ck
            assign out_o[p] = regs_i.cko ? ext_clk_i : regs_i.lat[p];
            assign oe_o[p]  = regs_i.cko | regs_i.dir[p];
        end else begin : g_pl
            assign out_o[p] = regs_i.lat[p];
            assign oe_o[p]  = regs_i.dir[p];
        end
    end
endmodule

// File: rtl/pio6_port.sv
module pio6_port
    import pio6_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic             bus_we_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    input  logic             ext_clk_i,
    input  logic [NPINS-1:0] pin_in_i,
    output logic [NPINS-1:0] pin_out_o,
    output logic [NPINS-1:0] pin_oe_o
);
    regs_t            regs;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] rb_val;

    pio6_regs u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i),
        .we_i(bus_we_i), .wdata_i(bus_wdata_i), .regs_o(regs)
    );

    pio6_sync #(.W(NPINS), .STAGES(2)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_in_i), .q_o(pin_sync)
    );

    pio6_pad u_pad (
        .regs_i(regs), .ext_clk_i(ext_clk_i), .out_o(pin_out_o), .oe_o(pin_oe_o)
    );

    always_comb begin
        for (int i = 0; i < NPINS; i++)
            rb_val[i] = regs.dir[i] ? regs.lat[i] : pin_sync[i];
        if (regs.cko) rb_val[0] = pin_sync[0];
        bus_rdata_o = '0;
        if (bus_addr_i == OFS_VAL) bus_rdata_o[NPINS-1:0] = rb_val;
        else if (bus_addr_i == OFS_DIR) begin
            bus_rdata_o[NPINS-1:0] = regs.dir;
            bus_rdata_o[CKO_BIT]   = regs.cko;
        end
    end
endmodule

// File: rtl/pio6_port_chk.sv
module pio6_port_chk
    import pio6_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [AW-1:0]    bus_addr_i,
    input logic             bus_we_i,
    input logic [DW-1:0]    bus_wdata_i,
    input logic [DW-1:0]    bus_rdata_o,
    input logic             ext_clk_i,
    input logic [NPINS-1:0] pin_out_o,
    input logic [NPINS-1:0] pin_oe_o
);
    AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[6] == 1'b0) else $error("rsv"); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i != OFS_VAL && bus_addr_i != OFS_DIR) |-> bus_rdata_o == '0) else $error("unmapped"); // R9
    AST_VAL_B7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == OFS_VAL) |-> bus_rdata_o[7] == 1'b0) else $error("b7"); // R8
    AST_DIR_WRITE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == OFS_DIR) |=> pin_oe_o[NPINS-1:1] == $past(bus_wdata_i[NPINS-1:1])) else $error("oe"); // R3
    AST_VAL_WRITE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == OFS_VAL) |=> pin_out_o[NPINS-1:1] == $past(bus_wdata_i[NPINS-1:1])) else $error("out"); // R5
    AST_CKO_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == OFS_DIR && bus_wdata_i[CKO_BIT]) |=> pin_oe_o[0]) else $error("cko"); // R7
endmodule

bind pio6_port pio6_port_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .ext_clk_i(ext_clk_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
);

// File: tb/pio6_port_tb.sv
module pio6_port_tb_top;
    localparam time TCLK = 10ns;

    logic       clk = 0, rst_n = 0;
    logic [7:0] addr = 0, wdata = 0;
    logic       we = 0, eclk = 0;
    logic [5:0] pin_in = 0;
    logic [7:0] rdata;
    logic [5:0] pout, poe;

    int n_tests = 0, n_fail = 0;

    // reference model state
    int m_lat = 0, m_dir = 0, m_cko = 0;
    int m_s1 = 0, m_s2 = 0;
    int cyc = 0;

    pio6_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_clk_i(eclk),
        .pin_in_i(pin_in), .pin_out_o(pout), .pin_oe_o(poe)
    );

    always #(TCLK/2) clk = ~clk;

    function automatic int exp_rd(input int a);
        int v = 0;
        if (a == 1) begin
            for (int i = 0; i < 6; i++) begin
                int b = ((m_dir >> i) & 1) ? ((m_lat >> i) & 1) : ((m_s2 >> i) & 1);
                if (i == 0 && m_cko != 0) b = m_s2 & 1;
                v |= b << i;
            end
        end else if (a == 5) v = m_dir | (m_cko << 7);
        return v;
    endfunction

    function automatic int exp_oe();
        return m_dir | m_cko;
    endfunction

    function automatic int exp_out();
        return m_cko != 0 ? ((m_lat & 6'h3e) | int'(eclk)) : m_lat;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // model update on each edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat = 0; m_dir = 0; m_cko = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            cyc++;
            m_s2 = m_s1; m_s1 = int'(pin_in);
            if (we && addr == 8'h01) m_lat = int'(wdata[5:0]);
            if (we && addr == 8'h05) begin m_dir = int'(wdata[5:0]); m_cko = int'(wdata[7]); end
        end
    end

    // continuous comparison every cycle, mid-low phase
    always @(negedge clk) if (rst_n) begin
        chk("R3/R7 oe", int'(poe), exp_oe());
        chk("R3/R7 out", int'(pout), exp_out());
        chk("R4/R11 rdata", int'(rdata), exp_rd(int'(addr)));
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1; addr = a; wdata = d; we = 1;
        @(posedge clk); #1; we = 0; addr = 8'h01;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
        #1; addr = a; #1; chk(req, int'(rdata), exp);
    endtask

    initial begin
        #(TCLK*20000); n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(TCLK*3);
        chk("R1 oe", int'(poe), 0); chk("R1 out", int'(pout), 0);
        rd_chk("R1 dir", 8'h05, 0);
        rst_n = 1;
        @(posedge clk); #1;
        // R5: latch write while input; read back shows pin, not latch
        pin_in = 6'h0a; wr(8'h01, 8'h35);
        @(posedge clk); @(posedge clk); #1;
        rd_chk("R5 input readback", 8'h01, 6'h0a);
        chk("R5 oe off", int'(poe), 0);
        // R10: switch to output, first cycle drives latch
        wr(8'h05, 8'h3f);
        chk("R10 out", int'(pout), 6'h35); chk("R10 oe", int'(poe), 6'h3f);
        rd_chk("R4 out readback", 8'h01, 6'h35);
        // mixed directions
        wr(8'h05, 8'h15);
        rd_chk("R4 mixed", 8'h01, (6'h35 & 6'h15) | (6'h0a & 6'h2a));
        // R6 two-edge latency
        pin_in = 6'h2a ^ 6'h3f; // toggles inputs
        @(posedge clk); #1; rd_chk("R6 after 1 edge", 8'h01, (6'h35 & 6'h15) | (6'h0a & 6'h2a));
        @(posedge clk); #1; rd_chk("R6 after 2 edges", 8'h01, (6'h35 & 6'h15) | (6'h15 & 6'h2a));
        // R8 reserved bits
        wr(8'h05, 8'h7f); rd_chk("R8 dir b6", 8'h05, 8'h3f);
        wr(8'h01, 8'hff); rd_chk("R8 val b6/b7", 8'h01, 8'h3f);
        // R9 unmapped
        wr(8'h02, 8'h00); wr(8'h85, 8'h00);
        rd_chk("R9 no effect dir", 8'h05, 8'h3f);
        rd_chk("R9 unmapped read", 8'h03, 0);
        rd_chk("R9 unmapped read hi", 8'h81, 0);
        // R7 clock override
        wr(8'h01, 8'h00); wr(8'h05, 8'h80);
        pin_in = 6'h01;
        for (int k = 0; k < 6; k++) begin
            #2 eclk = ~eclk; #1;
            chk("R7 pin0 follows clk", int'(pout[0]), int'(eclk));
            chk("R7 oe0", int'(poe), 1);
            @(posedge clk); #1;
        end
        rd_chk("R7 bit0 is pin", 8'h01, 6'h01);
        rd_chk("R7 readback", 8'h05, 8'h80);
        wr(8'h05, 8'h01); chk("R7 release", int'(pout[0]), 0);
        // R2 write strobe needed
        #1; addr = 8'h05; wdata = 8'h3f; @(posedge clk); #1;
        rd_chk("R2 no strobe", 8'h05, 8'h01);
        repeat (3) @(posedge clk);
        #2;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule